// File: doc/BRIEF.md
# Asymmetric Dual-Port FP/INT Issue Router

This block sits between an in-order queue of arithmetic operations and two issue ports, each of which feeds a group of 64 lanes. Every operation carries a one-bit kind (floating-point or integer) and an ID. Each cycle the router looks at the two oldest queue entries and decides how many to take. It takes zero, one or two, always oldest first. It then steers each accepted operation to a port.

The ports are not alike. Port 0 reaches only a floating-point lane group. Port 1 is a single dispatch path that can feed either an integer lane group or a second floating-point group, one of them per cycle. A mode input selects the wiring scheme:

- **Shared mode**: port 1 takes integer or extra float work.
- **Split mode**: port 1 is integer-only.
- **Unified mode**: both ports carry the same kind in a cycle.

Accepted operations appear on registered per-port strobes one clock later. A counter tracks the cycles in which any port was used.

Top module: `fp_int_issue_router`

## Requirements
- R1: In shared mode (mode 2'd0, and also 2'd3), a float op (kind 1'b0) at the head issues on port 0. A valid second op of either kind issues on port 1 in the same cycle.
- R2: In shared mode, an integer op (kind 1'b1) at the head issues on port 1. The second op issues on port 0 in the same cycle only if it is a float op.
- R3: In shared and split modes, port 0 never issues an integer op.
- R4: Port 1 issues at most one op per cycle. Two integer ops at the head in shared or split mode therefore issue in separate cycles.
- R5: In shared mode, a run of N float ops issues in ceil(N/2) cycles.
- R6: In split mode (mode 2'd1), port 1 issues only integer ops. A run of N float ops takes N cycles with port 1 idle.
- R7: In unified mode (mode 2'd2), the head op issues on port 0. The second op issues on port 1 in the same cycle only if it has the same kind.
- R8: At most the two head entries are taken per cycle, in program order. hd1_ready is never high unless the head entry is valid and taken in the same cycle.
- R9: An op accepted at a clock edge (valid and ready high) appears on its port's strobe, kind and ID right after that edge, for exactly one cycle.
- R10: slot_count is zero after synchronous reset. It rises by one with every cycle in which at least one port strobe is high, and otherwise holds.
- R11: While reset is high, both ready outputs and both issue strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | 0 shared, 1 split, 2 unified, 3 treated as shared |
| hd0_valid | input | 1 | Oldest queue entry present |
| hd0_kind | input | 1 | Oldest entry kind: 0 float, 1 integer |
| hd0_id | input | ID_W | Oldest entry ID |
| hd0_ready | output | 1 | Oldest entry accepted when valid |
| hd1_valid | input | 1 | Second-oldest entry present |
| hd1_kind | input | 1 | Second entry kind |
| hd1_id | input | ID_W | Second entry ID |
| hd1_ready | output | 1 | Second entry accepted this cycle |
| p0_fire | output | 1 | Port 0 issue strobe |
| p0_kind | output | 1 | Kind issued on port 0 |
| p0_id | output | ID_W | ID issued on port 0 |
| p1_fire | output | 1 | Port 1 issue strobe |
| p1_kind | output | 1 | Kind issued on port 1 |
| p1_id | output | ID_W | ID issued on port 1 |
| slot_count | output | CNT_W | Count of cycles with any issue |

## Verification
The ready outputs are combinational, so the bench drives the head window on the falling edge and samples both readies 1 ns later, in the same cycle. Port strobes, kinds and IDs come from one register stage, and slot_count is updated at that same edge. The bench therefore checks all of them at the next falling edge, one edge after acceptance. For each stream, a spec model predicts the routing cycle by cycle, and the bench compares the total number of issue cycles and the slot_count increase against the values given in the requirements.

// File: rtl/issue_pkg.sv
package issue_pkg;

    localparam int LANES_PER_PORT = 64;
    localparam int NUM_PORTS      = 2;
    localparam int TOTAL_LANES    = LANES_PER_PORT * NUM_PORTS;

    localparam logic KIND_FP  = 1'b0;
    localparam logic KIND_INT = 1'b1;

    typedef enum logic [1:0] {
        MODE_SHARED  = 2'd0,
        MODE_SPLIT   = 2'd1,
        MODE_UNIFIED = 2'd2,
        MODE_RSVD    = 2'd3
    } route_mode_e;

    // Which head entry a port takes this cycle, if any
    typedef struct packed {
        logic fire;
        logic from_second;
    } port_pick_t;

    // The reserved encoding behaves like shared wiring
    function automatic route_mode_e decode_mode(input logic [1:0] m);
        route_mode_e r;
        r = route_mode_e'(m);
        if (r == MODE_RSVD) r = MODE_SHARED;
        return r;
    endfunction

endpackage

// File: rtl/route_select.sv
module route_select
    import issue_pkg::*;
(
    input  route_mode_e mode,
    input  logic        v0,
    input  logic        k0,
    input  logic        v1,
    input  logic        k1,
    output port_pick_t  pick0,
    output port_pick_t  pick1,
    output logic        pair
);
    always_comb begin
        pick0 = '0;
        pick1 = '0;
        pair  = 1'b0;
        case (mode)
            MODE_UNIFIED: begin
                // same kind on both ports, head always to port 0
                pick0.fire        = v0;
                pair              = v0 && v1 && (k1 == k0);
                pick1.fire        = pair;
                pick1.from_second = 1'b1;
            end
            MODE_SPLIT: begin
                if (k0 == KIND_FP) begin
                    pick0.fire        = v0;
                    pair              = v0 && v1 && (k1 == KIND_INT);
                    pick1.fire        = pair;
                    pick1.from_second = 1'b1;
                end else begin
                    pick1.fire        = v0;
                    pair              = v0 && v1 && (k1 == KIND_FP);
                    pick0.fire        = pair;
                    pick0.from_second = 1'b1;
                end
            end
            default: begin
                // shared path: port 1 serves integer or extra float
                if (k0 == KIND_FP) begin
                    pick0.fire        = v0;
                    pair              = v0 && v1;
                    pick1.fire        = pair;
                    pick1.from_second = 1'b1;
                end else begin
                    pick1.fire        = v0;
                    pair              = v0 && v1 && (k1 == KIND_FP);
                    pick0.fire        = pair;
                    pick0.from_second = 1'b1;
                end
            end
        endcase
    end
endmodule

// File: rtl/issue_stage.sv
module issue_stage #(
    parameter int ID_W = 6
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            fire_in,
    input  logic            kind_in,
    input  logic [ID_W-1:0] id_in,
    output logic            fire_q,
    output logic            kind_q,
    output logic [ID_W-1:0] id_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            fire_q <= 1'b0;
            kind_q <= 1'b0;
            id_q   <= '0;
        end else begin
            fire_q <= fire_in;
            if (fire_in) begin
                kind_q <= kind_in;
                id_q   <= id_in;
            end
        end
    end
endmodule

// File: rtl/slot_counter.sv
module slot_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bump,
    output logic [CNT_W-1:0] count
);
    always_ff @(posedge clk) begin
        if (rst)       count <= '0;
        else if (bump) count <= count + 1'b1;
    end
endmodule

// File: rtl/fp_int_issue_router.sv
module fp_int_issue_router
    import issue_pkg::*;
#(
    parameter int ID_W  = 6,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       mode,
    input  logic             hd0_valid,
    input  logic             hd0_kind,
    input  logic [ID_W-1:0]  hd0_id,
    output logic             hd0_ready,
    input  logic             hd1_valid,
    input  logic             hd1_kind,
    input  logic [ID_W-1:0]  hd1_id,
    output logic             hd1_ready,
    output logic             p0_fire,
    output logic             p0_kind,
    output logic [ID_W-1:0]  p0_id,
    output logic             p1_fire,
    output logic             p1_kind,
    output logic [ID_W-1:0]  p1_id,
    output logic [CNT_W-1:0] slot_count
);
    route_mode_e eff_mode;
    port_pick_t  pick0, pick1;
    logic        pair;
    logic [NUM_PORTS-1:0] pick_fire, pick_sec, fire_q, kind_q;
    logic [ID_W-1:0]      id_q [NUM_PORTS];

    assign eff_mode = decode_mode(mode);

    route_select u_sel (
        .mode  (eff_mode),
        .v0    (hd0_valid && !rst),
        .k0    (hd0_kind),
        .v1    (hd1_valid),
        .k1    (hd1_kind),
        .pick0 (pick0),
        .pick1 (pick1),
        .pair  (pair)
    );

    assign hd0_ready = !rst;
    assign hd1_ready = pair;

    assign pick_fire = {pick1.fire, pick0.fire};
    assign pick_sec  = {pick1.from_second, pick0.from_second};

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        logic            sel_kind;
        logic [ID_W-1:0] sel_id;
        assign sel_kind = pick_sec[p] ? hd1_kind : hd0_kind;
        assign sel_id   = pick_sec[p] ? hd1_id   : hd0_id;
        issue_stage #(.ID_W(ID_W)) u_stage (
            .clk     (clk),
            .rst     (rst),
            .fire_in (pick_fire[p]),
            .kind_in (sel_kind),
            .id_in   (sel_id),
            .fire_q  (fire_q[p]),
            .kind_q  (kind_q[p]),
            .id_q    (id_q[p])
        );
    end

    slot_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .bump  (|pick_fire),
        .count (slot_count)
    );

    assign p0_fire = fire_q[0];
    assign p0_kind = kind_q[0];
    assign p0_id   = id_q[0];
    assign p1_fire = fire_q[1];
    assign p1_kind = kind_q[1];
    assign p1_id   = id_q[1];

    a_r3_p0_float_only: assert property (@(posedge clk) disable iff (rst)
        (p0_fire && $past(eff_mode) != MODE_UNIFIED) |-> p0_kind == KIND_FP);

    a_r6_split_p1_int: assert property (@(posedge clk) disable iff (rst)
        (p1_fire && $past(eff_mode) == MODE_SPLIT) |-> p1_kind == KIND_INT);

    a_r7_unified_same_kind: assert property (@(posedge clk) disable iff (rst)
        (p0_fire && p1_fire && $past(eff_mode) == MODE_UNIFIED) |-> p0_kind == p1_kind);

    a_r8_second_needs_first: assert property (@(posedge clk) disable iff (rst)
        hd1_ready |-> (hd0_valid && hd0_ready));

    a_r9_issue_follows_accept: assert property (@(posedge clk) disable iff (rst)
        (p0_fire || p1_fire) |-> $past(hd0_valid && hd0_ready));

    a_r10_count_step: assert property (@(posedge clk) disable iff (rst)
        (p0_fire || p1_fire) |-> slot_count == $past(slot_count) + 1'b1);

    a_r10_count_hold: assert property (@(posedge clk) disable iff (rst)
        !(p0_fire || p1_fire) |-> $stable(slot_count));

    a_r11_reset_quiet: assert property (@(posedge clk)
        rst |-> !hd0_ready && !hd1_ready);
endmodule

// File: tb/sim_fp_int_issue_router.sv
`timescale 1ns/1ps
module sim_fp_int_issue_router;
    localparam int ID_W  = 6;
    localparam int CNT_W = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [1:0] mode = 2'd0;
    logic hd0_valid = 1'b0, hd0_kind = 1'b0, hd1_valid = 1'b0, hd1_kind = 1'b0;
    logic [ID_W-1:0] hd0_id = '0, hd1_id = '0;
    logic hd0_ready, hd1_ready, p0_fire, p0_kind, p1_fire, p1_kind;
    logic [ID_W-1:0] p0_id, p1_id;
    logic [CNT_W-1:0] slot_count;

    int checks = 0;
    int errors = 0;
    logic q_kind [16];
    logic [ID_W-1:0] q_id [16];
    int q_len = 0;

    always #2 clk = ~clk;

    fp_int_issue_router #(.ID_W(ID_W), .CNT_W(CNT_W)) u0 (
        .clk(clk), .rst(rst), .mode(mode),
        .hd0_valid(hd0_valid), .hd0_kind(hd0_kind), .hd0_id(hd0_id), .hd0_ready(hd0_ready),
        .hd1_valid(hd1_valid), .hd1_kind(hd1_kind), .hd1_id(hd1_id), .hd1_ready(hd1_ready),
        .p0_fire(p0_fire), .p0_kind(p0_kind), .p0_id(p0_id),
        .p1_fire(p1_fire), .p1_kind(p1_kind), .p1_id(p1_id),
        .slot_count(slot_count)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // 'F' float (kind 0), 'I' integer (kind 1)
    task automatic load(input string s, input int base);
        q_len = s.len();
        for (int i = 0; i < q_len; i++) begin
            q_kind[i] = (s[i] == "I");
            q_id[i]   = ID_W'(base + i);
        end
    endtask

    // Routing expected from the requirements
    function automatic void model(input logic [1:0] m, input logic v1, input logic k0,
                                  input logic k1, output logic f0, output logic s0,
                                  output logic f1, output logic s1);
        f0 = 0; s0 = 0; f1 = 0; s1 = 0;
        if (m == 2'd2) begin
            f0 = 1;
            if (v1 && k0 == k1) begin f1 = 1; s1 = 1; end
        end else begin
            if (k0 == 1'b0) f0 = 1; else f1 = 1;
            if (v1) begin
                if (k0 == 1'b0 && (k1 == 1'b1 || m != 2'd1)) begin f1 = 1; s1 = 1; end
                else if (k0 == 1'b1 && k1 == 1'b0) begin f0 = 1; s0 = 1; end
            end
        end
    endfunction

    // Called at a falling edge; streams the loaded queue in the given mode
    task automatic run_stream(input logic [1:0] m, input int exp_cycles, input string req);
        int ptr = 0;
        int cyc = 0;
        int p1_seen = 0;
        logic [CNT_W-1:0] cnt0 = slot_count;
        logic f0, s0, f1, s1;
        mode = m;
        while (ptr < q_len) begin
            hd0_valid = 1'b1; hd0_kind = q_kind[ptr]; hd0_id = q_id[ptr];
            hd1_valid = (ptr + 1 < q_len);
            hd1_kind  = hd1_valid ? q_kind[ptr+1] : 1'b0;
            hd1_id    = hd1_valid ? q_id[ptr+1] : '0;
            #1;
            model(m, hd1_valid, hd0_kind, hd1_kind, f0, s0, f1, s1);
            chk(hd0_ready == 1'b1, {req, " R8 hd0_ready"}, int'(hd0_ready), 1);
            chk(hd1_ready == ((f0 && s0) || (f1 && s1)), {req, " R8 hd1_ready"},
                int'(hd1_ready), int'((f0 && s0) || (f1 && s1)));
            @(negedge clk);
            // R9: strobes due one edge after acceptance
            chk(p0_fire == f0, {req, " R9 p0_fire"}, int'(p0_fire), int'(f0));
            chk(p1_fire == f1, {req, " R9 p1_fire"}, int'(p1_fire), int'(f1));
            if (f0) chk(p0_id == q_id[ptr + int'(s0)], {req, " R9 p0_id"},
                        int'(p0_id), int'(q_id[ptr + int'(s0)]));
            if (f1) chk(p1_id == q_id[ptr + int'(s1)], {req, " R9 p1_id"},
                        int'(p1_id), int'(q_id[ptr + int'(s1)]));
            if (f0 && m != 2'd2) chk(p0_kind == 1'b0, {req, " R3 p0 float"}, int'(p0_kind), 0);
            if (p1_fire) p1_seen++;
            ptr += (s0 || s1) ? 2 : 1;
            cyc++;
        end
        hd0_valid = 1'b0; hd1_valid = 1'b0;
        chk(cyc == exp_cycles, {req, " issue cycles"}, cyc, exp_cycles);
        chk(slot_count == cnt0 + CNT_W'(cyc), {req, " R10 count"}, int'(slot_count), int'(cnt0) + cyc);
        if (m == 2'd1 && req == "R6 split float") chk(p1_seen == 0, "R6 p1 idle", p1_seen, 0);
        @(negedge clk);
        chk(!p0_fire && !p1_fire, {req, " R9 single pulse"}, int'(p0_fire || p1_fire), 0);
    endtask

    task automatic t_reset();
        rst = 1'b1; hd0_valid = 1'b1; hd1_valid = 1'b1;
        repeat (3) @(negedge clk);
        chk(hd0_ready == 0 && hd1_ready == 0, "R11 ready low in reset", int'(hd0_ready || hd1_ready), 0);
        chk(p0_fire == 0 && p1_fire == 0, "R11 strobes low in reset", int'(p0_fire || p1_fire), 0);
        chk(slot_count == 0, "R10 count zero after reset", int'(slot_count), 0);
        hd0_valid = 1'b0; hd1_valid = 1'b0;
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_order();
        logic [CNT_W-1:0] c0 = slot_count;
        mode = 2'd0;
        hd0_valid = 1'b0; hd1_valid = 1'b1; hd1_kind = 1'b0; hd1_id = 6'd9;
        #1;
        chk(hd1_ready == 1'b0, "R8 second not taken without first", int'(hd1_ready), 0);
        @(negedge clk);
        chk(!p0_fire && !p1_fire, "R8 nothing issued", int'(p0_fire || p1_fire), 0);
        chk(slot_count == c0, "R10 count holds when idle", int'(slot_count), int'(c0));
        hd1_valid = 1'b0;
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        load("FFFFFFF", 0);        run_stream(2'd0, 4, "R5 shared float");
        load("FFFFFFF", 0);        run_stream(2'd3, 4, "R1 reserved mode as shared");
        load("FFFF", 10);          run_stream(2'd1, 4, "R6 split float");
        load("IFFIIIF", 20);       run_stream(2'd0, 4, "R2 shared mix");
        load("IIII", 30);          run_stream(2'd0, 4, "R4 shared int pairs");
        load("FIIFFF", 40);        run_stream(2'd1, 4, "R3 split mix");
        load("IIFFIFF", 50);       run_stream(2'd2, 4, "R7 unified");
        load("FIFI", 60);          run_stream(2'd2, 4, "R7 unified alternating");
        t_order();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule